// File: doc/BRIEF.md
# Four-Channel Timer Capture Unit

This block takes snapshots of a free-running 16-bit up-counter into four independent 16-bit capture registers. Each channel can be triggered by a transition on its own external input pin, by a software write to the channel's low register byte, or by both. Software can then read the stored value over a byte-wide register port. This lets the block timestamp external events, or sample the running timer without tearing between its two bytes.

Each external input passes through a two-stage synchronizer before edge detection. Channel 0 has its own edge-polarity bit. Channels 1 to 3 share one edge-select bit, and that bit uses the opposite encoding. Every external capture sets the channel's interrupt flag. Software clears a flag by writing 1 to its bit.

Register map (byte addresses): 0 = edge control, 1 = mode, 2 = interrupt flags, 3 = timer low byte, 4 = timer high byte, 8+2n = channel n low byte, 9+2n = channel n high byte. All other addresses read 0.

Top module: `capture_unit4`

## Requirements
- R1: After reset (rst_n low, asynchronous), every readable register reads 0: control, mode, flags, the timer and all capture registers. irq_o is 0.
- R2: The timer increases by 1 on every clock after reset and wraps from FFFFh to 0000h. Its low byte reads at address 3 and its high byte at address 4. Writes to these two addresses are ignored.
- R3: The mode register at address 1 holds a 2-bit field for channel n in bits [2n+1:2n]. Field value 00 disables the channel: pin edges and low-byte writes leave its capture register and flag unchanged.
- R4: With field 01 on channel 0, control bit 0 selects the edge. Value 0 captures on a falling pin edge and value 1 captures on a rising pin edge. The other edge is ignored.
- R5: With field 01 on channels 1 to 3, control bit 1 selects the edge for all three channels. Value 0 captures on a rising edge and value 1 captures on a falling edge.
- R6: Field 11 captures on both rising and falling pin edges, and also enables write-triggered capture.
- R7: With field 10 or 11, a write to address 8+2n stores into channel n the timer value readable in the cycle of the write. The written data is discarded. Writes to a high byte (9+2n), and low-byte writes with field 00 or 01, have no effect.
- R8: A pin transition present at clock edge k causes the capture at edge k+2. The value stored is the timer value readable during the cycle just before edge k+2.
- R9: An external capture on channel n sets flag bit n at address 2 and irq_o[n]. A write-triggered capture does not set the flag.
- R10: Writing 1 to a bit of address 2 clears that flag, and writing 0 leaves it unchanged. If an external capture and a clear hit the same flag in the same cycle, the flag ends up set.
- R11: If an external edge and a low-byte write fall on the same channel in the same cycle, one capture stores the current timer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 4 | External capture inputs, bit n for channel n |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 4 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| irq_o | output | 4 | Per-channel capture interrupt flags |

## Verification
Two pairs of functions can meet in one cycle. The first pair is an external edge capture and a low-byte write capture on the same channel. The second pair is an edge-triggered flag set and a write-1-to-clear of that flag. The bench provokes both by sweeping the write across offsets of zero to four cycles after a pin transition, so exactly one offset hits the detection cycle. A behavioural reference model with its own synchronizer history and timer is compared against the read port and irq_o on every clock, so a double capture, a lost set or a wrongly timed stored value shows up as a mismatch.

// File: rtl/capu_pkg.sv
package capu_pkg;

   typedef enum logic [1:0] {
      CAPM_OFF  = 2'b00,
      CAPM_EDGE = 2'b01,
      CAPM_WR   = 2'b10,
      CAPM_BOTH = 2'b11
   } capmode_e;

   localparam int unsigned CAPU_A_CTRL     = 0;
   localparam int unsigned CAPU_A_MODE     = 1;
   localparam int unsigned CAPU_A_FLAG     = 2;
   localparam int unsigned CAPU_A_TLO      = 3;
   localparam int unsigned CAPU_A_THI      = 4;
   localparam int unsigned CAPU_A_CAP_BASE = 8;

endpackage

// File: rtl/capu_timer.sv
module capu_timer #(
   parameter int unsigned TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [TW-1:0] tmr_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_o <= '0;
      else        tmr_o <= tmr_o + 1'b1;
   end

   // R2
   tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_o != '1) |=> (tmr_o == $past(tmr_o) + 1'b1));

endmodule

// File: rtl/capu_sync_edge.sv
module capu_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES:0] sh_q;
   logic            cur, prv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin_i};
   end

   assign cur    = sh_q[STAGES-1];
   assign prv    = sh_q[STAGES];
   assign rise_o = cur & ~prv;
   assign fall_o = ~cur & prv;

   // R8
   rise_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

   // R8
   fall_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/capu_chan.sv
module capu_chan
   import capu_pkg::*;
#(
   parameter int unsigned TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  capmode_e      mode_i,
   input  logic          rise_i,
   input  logic          fall_i,
   input  logic          pick_rise_i,
   input  logic          wr_low_i,
   input  logic          clr_i,
   input  logic [TW-1:0] tmr_i,
   output logic [TW-1:0] cap_o,
   output logic          flag_o
);

   logic sel_edge, ext_evt, wr_cap, cap_en;

   assign sel_edge = pick_rise_i ? rise_i : fall_i;

   always_comb begin
      unique case (mode_i)
         CAPM_EDGE: ext_evt = sel_edge;
         CAPM_BOTH: ext_evt = rise_i | fall_i;
         default:   ext_evt = 1'b0;
      endcase
   end

   assign wr_cap = wr_low_i & mode_i[1];
   assign cap_en = ext_evt | wr_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_o <= '0;
      else if (cap_en) cap_o <= tmr_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_o <= 1'b0;
      else if (ext_evt) flag_o <= 1'b1;
      else if (clr_i)   flag_o <= 1'b0;
   end

   // R3
   off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == CAPM_OFF) |=> $stable(cap_o));

   // R9
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !ext_evt) |=> !flag_o);

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_evt |=> flag_o);

   // R10
   clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !ext_evt) |=> !flag_o);

endmodule

// File: rtl/capture_unit4.sv
module capture_unit4
   import capu_pkg::*;
#(
   parameter int unsigned NCH         = 4,
   parameter int unsigned DW          = 8,
   parameter int unsigned AW          = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NCH-1:0] cap_pin_i,
   input  logic          bus_wr_i,
   input  logic [AW-1:0] bus_addr_i,
   input  logic [DW-1:0] bus_wdata_i,
   output logic [DW-1:0] bus_rdata_o,
   output logic [NCH-1:0] irq_o
);

   localparam int unsigned TW = 2 * DW;
   localparam int unsigned MW = 2 * NCH;
   localparam logic [AW-1:0] A_CTRL = AW'(CAPU_A_CTRL);
   localparam logic [AW-1:0] A_MODE = AW'(CAPU_A_MODE);
   localparam logic [AW-1:0] A_FLAG = AW'(CAPU_A_FLAG);
   localparam logic [AW-1:0] A_TLO  = AW'(CAPU_A_TLO);
   localparam logic [AW-1:0] A_THI  = AW'(CAPU_A_THI);

   if (MW > DW) begin : g_err_mode
      $error("capture_unit4: mode fields do not fit one register byte");
   end
   if (CAPU_A_CAP_BASE + 2 * NCH > (1 << AW)) begin : g_err_addr
      $error("capture_unit4: address width too small for the channel count");
   end
   if (SYNC_STAGES < 2) begin : g_err_sync
      $error("capture_unit4: synchronizer needs at least two stages");
   end

   logic [1:0]    ctrl_q;
   logic [MW-1:0] mode_q;
   logic [TW-1:0] tmr;
   logic [TW-1:0] cap_q [NCH];
   logic [NCH-1:0] flag_w;
   logic          flag_wr;

   assign flag_wr = bus_wr_i && (bus_addr_i == A_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= '0;
      end else if (bus_wr_i) begin
         if (bus_addr_i == A_CTRL) ctrl_q <= bus_wdata_i[1:0];
         if (bus_addr_i == A_MODE) mode_q <= bus_wdata_i[MW-1:0];
      end
   end

   capu_timer #(.TW(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tmr_o (tmr)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic [AW-1:0] A_LO = AW'(CAPU_A_CAP_BASE + 2 * g);
      logic rise, fall, pick_rise, wr_low;

      capu_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (cap_pin_i[g]),
         .rise_o (rise),
         .fall_o (fall)
      );

      if (g == 0) begin : g_pol_own
         assign pick_rise = ctrl_q[0];
      end else begin : g_pol_shared
         assign pick_rise = ~ctrl_q[1];
      end

      assign wr_low = bus_wr_i && (bus_addr_i == A_LO);

      capu_chan #(.TW(TW)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .mode_i      (capmode_e'(mode_q[2*g +: 2])),
         .rise_i      (rise),
         .fall_i      (fall),
         .pick_rise_i (pick_rise),
         .wr_low_i    (wr_low),
         .clr_i       (flag_wr && bus_wdata_i[g]),
         .tmr_i       (tmr),
         .cap_o       (cap_q[g]),
         .flag_o      (flag_w[g])
      );

      // R7
      hi_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr_i && bus_addr_i == A_LO + 1'b1 && !rise && !fall) |=> $stable(cap_q[g]));
   end

   assign irq_o = flag_w;

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == A_CTRL) bus_rdata_o[1:0] = ctrl_q;
      if (bus_addr_i == A_MODE) bus_rdata_o[MW-1:0] = mode_q;
      if (bus_addr_i == A_FLAG) bus_rdata_o[NCH-1:0] = flag_w;
      if (bus_addr_i == A_TLO)  bus_rdata_o = tmr[DW-1:0];
      if (bus_addr_i == A_THI)  bus_rdata_o = tmr[TW-1:DW];
      for (int n = 0; n < NCH; n++) begin
         if (bus_addr_i == AW'(CAPU_A_CAP_BASE + 2 * n))     bus_rdata_o = cap_q[n][DW-1:0];
         if (bus_addr_i == AW'(CAPU_A_CAP_BASE + 2 * n + 1)) bus_rdata_o = cap_q[n][TW-1:DW];
      end
   end

endmodule

// File: tb/test_capture_unit4.sv
`timescale 1ns/1ps
module test_capture_unit4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pins = '0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [3:0] irq;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   capture_unit4 i_capture_unit4 (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_pin_i   (pins),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_o       (irq)
   );

   // behavioural reference model
   logic [3:0]  m_s1, m_s2, m_s3;
   logic [15:0] m_tmr;
   logic [15:0] m_cap [4];
   logic [3:0]  m_flag;
   logic [1:0]  m_ctrl;
   logic [7:0]  m_mode;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_s3 = 0; m_tmr = 0; m_flag = 0; m_ctrl = 0; m_mode = 0;
         for (int n = 0; n < 4; n++) m_cap[n] = 0;
      end else begin
         for (int n = 0; n < 4; n++) begin
            bit rise, fall, pr, ext, wrc;
            int md;
            rise = m_s2[n] && !m_s3[n];
            fall = !m_s2[n] && m_s3[n];
            md   = (m_mode >> (2 * n)) & 3;
            pr   = (n == 0) ? m_ctrl[0] : !m_ctrl[1];
            ext  = (md == 1 && (pr ? rise : fall)) || (md == 3 && (rise || fall));
            wrc  = bus_wr && bus_addr == 4'(8 + 2 * n) && md >= 2;
            if (ext || wrc) m_cap[n] = m_tmr;
            if (bus_wr && bus_addr == 2 && bus_wdata[n]) m_flag[n] = 0;
            if (ext) m_flag[n] = 1;
         end
         if (bus_wr && bus_addr == 0) m_ctrl = bus_wdata[1:0];
         if (bus_wr && bus_addr == 1) m_mode = bus_wdata;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = pins;
         m_tmr = m_tmr + 16'd1;
      end
   end

   function automatic logic [7:0] m_read(input logic [3:0] a);
      case (a)
         0: return {6'd0, m_ctrl};
         1: return m_mode;
         2: return {4'd0, m_flag};
         3: return m_tmr[7:0];
         4: return m_tmr[15:8];
         8, 10, 12, 14: return m_cap[(a - 8) / 2][7:0];
         9, 11, 13, 15: return m_cap[(a - 9) / 2][15:8];
         default: return 8'd0;
      endcase
   endfunction

   task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      n_cmp++;
      if (bus_rdata !== m_read(bus_addr)) begin
         n_bad++;
         $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, bus_addr, bus_rdata, m_read(bus_addr));
      end
      n_cmp++;
      if (irq !== m_flag) begin
         n_bad++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_flag);
      end
      bus_wr = w; bus_addr = a; bus_wdata = d;
   endtask

   task automatic sweep(input int cnt);
      for (int i = 0; i < cnt; i++)
         cyc(0, (i % 9 == 8) ? 4'd2 : 4'(8 + i % 9), 8'd0);
   endtask

   initial begin
      // R1 reset state
      tag = "R1";
      for (int a = 0; a < 4; a++) cyc(0, 4'(a), 0);
      @(negedge clk); rst_n = 1'b1;
      for (int a = 0; a < 16; a++) cyc(0, 4'(a), 0);

      // R2 timer counting and full wrap
      tag = "R2";
      cyc(1, 3, 8'hFF); cyc(1, 4, 8'hFF);
      for (int i = 0; i < 66000; i++) cyc(0, (i % 2) ? 4'd3 : 4'd4, 0);

      // R3 disabled channels
      tag = "R3";
      pins = 4'hF; sweep(12);
      pins = 4'h0; sweep(12);
      for (int n = 0; n < 4; n++) cyc(1, 4'(8 + 2 * n), 8'h5A);
      sweep(12);

      // R4 channel 0 polarity
      tag = "R4";
      cyc(1, 1, 8'h01); cyc(1, 0, 8'h00);
      pins[0] = 1'b1; sweep(9);
      pins[0] = 1'b0; sweep(9);
      cyc(1, 2, 8'h0F);
      cyc(1, 0, 8'h01);
      pins[0] = 1'b1; sweep(9);
      pins[0] = 1'b0; sweep(9);
      cyc(1, 2, 8'h0F);

      // R5 shared polarity of channels 1..3
      tag = "R5";
      cyc(1, 1, 8'h54); cyc(1, 0, 8'h00);
      pins = 4'hE; sweep(18);
      pins = 4'h0; sweep(18);
      cyc(1, 2, 8'h0F);
      cyc(1, 0, 8'h02);
      pins = 4'hE; sweep(18);
      pins = 4'h0; sweep(18);
      cyc(1, 2, 8'h0F);

      // R7 write-triggered capture, high-byte writes ignored
      tag = "R7";
      cyc(1, 1, 8'hAA);
      for (int n = 0; n < 4; n++) begin cyc(1, 4'(8 + 2 * n), 8'hC3); sweep(3); end
      for (int n = 0; n < 4; n++) begin cyc(1, 4'(9 + 2 * n), 8'h3C); sweep(3); end
      cyc(1, 1, 8'h55);
      for (int n = 0; n < 4; n++) begin cyc(1, 4'(8 + 2 * n), 8'h11); sweep(3); end

      // R9 write capture leaves flags clear, edges in mode 10 ignored
      tag = "R9";
      cyc(1, 1, 8'hAA);
      pins = 4'hF; sweep(9);
      for (int n = 0; n < 4; n++) begin cyc(1, 4'(8 + 2 * n), 0); cyc(0, 2, 0); end
      pins = 4'h0; sweep(9);

      // R6 both edges plus write
      tag = "R6";
      cyc(1, 1, 8'hFF);
      pins = 4'h5; sweep(9);
      pins = 4'hA; sweep(9);
      pins = 4'h0; sweep(9);
      for (int n = 0; n < 4; n++) begin cyc(1, 4'(8 + 2 * n), 0); sweep(2); end
      cyc(1, 2, 8'h0F);

      // R8 latency of a single edge on channel 0
      tag = "R8";
      cyc(1, 1, 8'h01); cyc(1, 0, 8'h01);
      for (int k = 0; k < 3; k++) begin
         pins[0] = 1'b1;
         for (int i = 0; i < 6; i++) cyc(0, (i % 2) ? 4'd9 : 4'd8, 0);
         pins[0] = 1'b0;
         for (int i = 0; i < 6 + k; i++) cyc(0, 2, 0);
      end
      cyc(1, 2, 8'h0F);

      // R10 clear versus set in the same cycle
      tag = "R10";
      cyc(1, 1, 8'h55); cyc(1, 0, 8'h01);
      for (int off = 0; off < 5; off++) begin
         pins = 4'hF;
         for (int i = 0; i < off; i++) cyc(0, 2, 0);
         cyc(1, 2, 8'h0F);
         cyc(0, 2, 0); cyc(0, 2, 0); cyc(0, 2, 0);
         cyc(1, 2, 8'h05); cyc(0, 2, 0);
         cyc(1, 2, 8'h0F);
         pins = 4'h0; sweep(6);
      end

      // R11 edge and low-byte write on one channel in one cycle
      tag = "R11";
      cyc(1, 1, 8'hFF);
      for (int off = 0; off < 5; off++) begin
         pins[2] = ~pins[2];
         for (int i = 0; i < off; i++) cyc(0, 12, 0);
         cyc(1, 12, 8'h77);
         cyc(0, 12, 0); cyc(0, 13, 0); cyc(0, 2, 0);
         sweep(4);
      end

      // mixed random traffic (R6, R10, R11 interplay)
      tag = "R11";
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (i % 250 == 0) cyc(1, 1, 8'($urandom));
         else if (i % 250 == 1) cyc(1, 0, 8'($urandom_range(0, 3)));
         else if (r < 8) cyc(1, 4'(8 + 2 * $urandom_range(0, 3)), 8'($urandom));
         else if (r < 12) cyc(1, 2, 8'($urandom_range(0, 15)));
         else cyc(0, 4'($urandom_range(0, 15)), 0);
         if ($urandom_range(0, 9) == 0) pins = pins ^ 4'($urandom_range(0, 15));
      end

      cyc(0, 0, 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired in %s", tag);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule